// File: doc/BRIEF.md
# Polynomial Noise Source with Switchable Long Register

This block produces the pseudo-random bit streams that tone channels use to mask their square waves. It holds three linear-feedback shift registers of 4, 5 and 17 stages. All three advance together on each cycle in which the fast-clock tick input is high. A mode input shortens the long register to a 9-stage loop at run time, which gives a much shorter repeat period.

Each register presents one noise bit. The long register also presents its upper eight stages as a byte that a host reads as a random number. Synchronous reset loads every stage with one. A guard in the feedback path forces a one into the register whenever its active window holds all zeros. A change of mode therefore cannot leave the long register stuck.

The register state is named as follows. A 4-stage register `a[3:0]` and a 5-stage register `b[4:0]` are kept. A 17-stage register `c[16:0]` is also kept. Every step shifts each register one place toward its most significant stage and loads a new feedback bit into stage 0.

Top module: `noise_poly_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stage of all three registers is set to 1. Straight after reset `noise4_o`, `noise5_o` and `noise17_o` read 1 and `rand_o` reads 8'hFF.
- R2: On a step the 4-stage register becomes `{a[2:0], a[3]^a[2]}`, and `noise4_o` always shows `a[3]`.
- R3: On a step the 5-stage register becomes `{b[3:0], b[4]^b[2]}`, and `noise5_o` always shows `b[4]`.
- R4: With `short_mode_i` low, a step makes the long register `{c[15:0], c[16]^c[13]}`, and `noise17_o` shows `c[16]`.
- R5: With `short_mode_i` high, a step still shifts all 17 stages to `{c[15:0], f}`, with `f = c[8]^c[4]`, and `noise17_o` shows `c[8]`.
- R6: `rand_o` always equals `c[16:9]`, the upper eight stages of the long register, in either mode.
- R7: When `tick_i` is low at a clock edge, no register changes and all outputs keep their values.
- R8: When the active window of the long register (`c[16:0]` in long mode, `c[8:0]` in short mode) is all zeros at a step, the feedback bit loaded is 1 instead of the tap XOR.
- R9: Under continuous stepping, each sequence repeats with the period given here. `noise4_o` repeats every 15 steps and `noise5_o` every 31 steps. `rand_o` repeats every 511 steps in short mode and every 131071 steps in long mode.
- R10: A change of `short_mode_i` takes effect at the next step without clearing or reloading any stage. `noise17_o` follows the new mode at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Fast-clock enable; one step per high cycle |
| short_mode_i | input | 1 | 1 selects the 9-stage loop for the long register |
| noise4_o | output | 1 | Noise bit of the 4-stage register |
| noise5_o | output | 1 | Noise bit of the 5-stage register |
| noise17_o | output | 1 | Noise bit of the long register in its current length |
| rand_o | output | 8 | Upper eight stages of the long register |

## Verification
The bound checker checks several properties on every cycle. It checks the one-place shift of every register, the hold when no tick arrives, and the mode-dependent choice of the long noise bit. It checks that a forced one enters the long register from an all-zero window, and that the short registers never reach zero. Only the bench scenarios can show that the feedback taps yield the full repeat periods. The same holds for the all-zero guard firing right after a switch from long to short mode. Exact bit-for-bit sequences across mixed tick patterns and mode toggles are also shown only by the bench.

// File: rtl/noise_pkg.sv
package noise_pkg;

    localparam int LEN_A     = 4;
    localparam int LEN_B     = 5;
    localparam int LEN_LONG  = 17;
    localparam int LEN_SHORT = 9;
    localparam int RAND_W    = 8;

    // Index of the second feedback tap (the first is always the top stage)
    // for a maximal-length two-tap XOR loop of the given length.
    function automatic int tap_of(input int len);
        case (len)
            3:       return 1;
            4:       return 2;
            5:       return 2;
            6:       return 4;
            7:       return 5;
            9:       return 4;
            10:      return 6;
            11:      return 8;
            15:      return 13;
            17:      return 13;
            default: return len - 2;
        endcase
    endfunction

    typedef struct packed {
        logic bit_a;
        logic bit_b;
        logic bit_long;
    } noise_bits_t;

endpackage

// File: rtl/lfsr_fixed.sv
module lfsr_fixed #(
    parameter int LEN = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step_i,
    output logic [LEN-1:0] state_o
);
    localparam int TAP = noise_pkg::tap_of(LEN);

    logic [LEN-1:0] state_q;
    logic           zero_w;
    logic           fb_w;

    always_comb begin
        zero_w = (state_q == '0);
        fb_w   = (state_q[LEN-1] ^ state_q[TAP]) | zero_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '1;
        end else if (step_i) begin
            state_q <= {state_q[LEN-2:0], fb_w};
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/lfsr_dual.sv
module lfsr_dual #(
    parameter int LONG  = 17,
    parameter int SHORT = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_i,
    input  logic            short_i,
    output logic [LONG-1:0] state_o,
    output logic            bit_o
);
    localparam int TAP_L = noise_pkg::tap_of(LONG);
    localparam int TAP_S = noise_pkg::tap_of(SHORT);

    logic [LONG-1:0] state_q;
    logic            fb_long_w;
    logic            fb_short_w;
    logic            fb_w;
    logic            bit_short_w;

    always_comb begin
        fb_long_w = (state_q[LONG-1] ^ state_q[TAP_L]) | (state_q == '0);
    end

    generate
        if (SHORT < LONG) begin : g_short
            always_comb begin
                fb_short_w  = (state_q[SHORT-1] ^ state_q[TAP_S])
                            | (state_q[SHORT-1:0] == '0);
                bit_short_w = state_q[SHORT-1];
            end
        end else begin : g_no_short
            always_comb begin
                fb_short_w  = fb_long_w;
                bit_short_w = state_q[LONG-1];
            end
        end
    endgenerate

    always_comb begin
        fb_w  = short_i ? fb_short_w : fb_long_w;
        bit_o = short_i ? bit_short_w : state_q[LONG-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '1;
        end else if (step_i) begin
            state_q <= {state_q[LONG-2:0], fb_w};
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/noise_poly_gen.sv
module noise_poly_gen #(
    parameter int LEN_A     = noise_pkg::LEN_A,
    parameter int LEN_B     = noise_pkg::LEN_B,
    parameter int LEN_LONG  = noise_pkg::LEN_LONG,
    parameter int LEN_SHORT = noise_pkg::LEN_SHORT,
    parameter int RAND_W    = noise_pkg::RAND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              short_mode_i,
    output logic              noise4_o,
    output logic              noise5_o,
    output logic              noise17_o,
    output logic [RAND_W-1:0] rand_o
);
    localparam int RAND_LSB = LEN_LONG - RAND_W;

    logic [LEN_A-1:0]    st4;
    logic [LEN_B-1:0]    st5;
    logic [LEN_LONG-1:0] st17;
    logic                long_bit;
    noise_pkg::noise_bits_t bits;

    lfsr_fixed #(.LEN(LEN_A)) i_reg_a (
        .clk(clk), .rst(rst), .step_i(tick_i), .state_o(st4)
    );

    lfsr_fixed #(.LEN(LEN_B)) i_reg_b (
        .clk(clk), .rst(rst), .step_i(tick_i), .state_o(st5)
    );

    lfsr_dual #(.LONG(LEN_LONG), .SHORT(LEN_SHORT)) i_reg_long (
        .clk(clk), .rst(rst), .step_i(tick_i), .short_i(short_mode_i),
        .state_o(st17), .bit_o(long_bit)
    );

    always_comb begin
        bits.bit_a    = st4[LEN_A-1];
        bits.bit_b    = st5[LEN_B-1];
        bits.bit_long = long_bit;
    end

    assign noise4_o  = bits.bit_a;
    assign noise5_o  = bits.bit_b;
    assign noise17_o = bits.bit_long;
    assign rand_o    = st17[LEN_LONG-1:RAND_LSB];
endmodule

// File: rtl/noise_poly_gen_chk.sv
module noise_poly_gen_chk #(
    parameter int LEN_A     = noise_pkg::LEN_A,
    parameter int LEN_B     = noise_pkg::LEN_B,
    parameter int LEN_LONG  = noise_pkg::LEN_LONG,
    parameter int LEN_SHORT = noise_pkg::LEN_SHORT,
    parameter int RAND_W    = noise_pkg::RAND_W
) (
    input logic                clk,
    input logic                rst,
    input logic                tick_i,
    input logic                short_mode_i,
    input logic [LEN_A-1:0]    st4,
    input logic [LEN_B-1:0]    st5,
    input logic [LEN_LONG-1:0] st17,
    input logic                noise17_o,
    input logic [RAND_W-1:0]   rand_o
);
    logic win_zero;
    always_comb win_zero = short_mode_i ? (st17[LEN_SHORT-1:0] == '0) : (st17 == '0);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (st4 == '1 && st5 == '1 && st17 == '1));

    // R2
    shift4_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> st4[LEN_A-1:1] == $past(st4[LEN_A-2:0]));

    // R3
    shift5_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> st5[LEN_B-1:1] == $past(st5[LEN_B-2:0]));

    // R4
    shift17_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> st17[LEN_LONG-1:1] == $past(st17[LEN_LONG-2:0]));

    // R4
    long_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !short_mode_i) |=> (short_mode_i || noise17_o == $past(st17[LEN_LONG-2])));

    // R5
    short_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && short_mode_i) |=> (!short_mode_i || noise17_o == $past(st17[LEN_SHORT-2])));

    // R6
    rand_shift_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> rand_o[RAND_W-1:1] == $past(rand_o[RAND_W-2:0]));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(st4) && $stable(st5) && $stable(st17)));

    // R8
    zero_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && win_zero) |=> st17[0]);

    // R8
    short_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (st4 != '0 && st5 != '0));
endmodule

bind noise_poly_gen noise_poly_gen_chk i_chk (
    .clk(clk), .rst(rst), .tick_i(tick_i), .short_mode_i(short_mode_i),
    .st4(st4), .st5(st5), .st17(st17), .noise17_o(noise17_o), .rand_o(rand_o)
);

// File: tb/test_noise_poly_gen.sv
module test_noise_poly_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       short_mode_i = 1'b0;
    logic       noise4_o, noise5_o, noise17_o;
    logic [7:0] rand_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic       b4;
        logic       b5;
        logic       b17;
        logic [7:0] rnd;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    logic [3:0]  m4;
    logic [4:0]  m5;
    logic [16:0] m17;

    noise_poly_gen i_noise_poly_gen (
        .clk(clk), .rst(rst), .tick_i(tick_i), .short_mode_i(short_mode_i),
        .noise4_o(noise4_o), .noise5_o(noise5_o), .noise17_o(noise17_o),
        .rand_o(rand_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [16:0] nx17(input logic [16:0] s, input logic sm);
        logic fb;
        if (sm) fb = (s[8] ^ s[4]) | (s[8:0] == 9'd0);
        else    fb = (s[16] ^ s[13]) | (s == 17'd0);
        return {s[15:0], fb};
    endfunction

    task automatic chk(input bit ok, input string req, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    task automatic model_reset();
        m4 = '1; m5 = '1; m17 = '1;
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic step(input logic en, input logic sm, input string req);
        exp_t e;
        @(negedge clk);
        tick_i = en;
        short_mode_i = sm;
        if (en) begin
            m4  = {m4[2:0], m4[3] ^ m4[2]};
            m5  = {m5[3:0], m5[4] ^ m5[2]};
            m17 = nx17(m17, sm);
        end
        e.b4  = m4[3];
        e.b5  = m5[4];
        e.b17 = sm ? m17[8] : m17[16];
        e.rnd = m17[16:9];
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic sample();
        @(posedge clk);
        #2;
    endtask

    // Monitor: compares design outputs with queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(noise4_o == e.b4 && noise5_o == e.b5 && noise17_o == e.b17 && rand_o == e.rnd,
                    e.req,
                    $sformatf("got b4=%0b b5=%0b b17=%0b rnd=%02h exp b4=%0b b5=%0b b17=%0b rnd=%02h",
                              noise4_o, noise5_o, noise17_o, rand_o, e.b4, e.b5, e.b17, e.rnd));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [14:0]  seq4a, seq4b;
        logic [30:0]  seq5a, seq5b;
        logic [7:0]   snap;
        int           guard_hits;

        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state visible before the first step
        chk(noise4_o && noise5_o && noise17_o && rand_o == 8'hFF, "R1",
            $sformatf("got b4=%0b b5=%0b b17=%0b rnd=%02h exp 1 1 1 ff",
                      noise4_o, noise5_o, noise17_o, rand_o));

        // R2 R3 R4 R6 long mode free run
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R4");
        // R7 hold with no tick
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R7");
        // R5 short mode run
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, "R5");
        // R7 hold in short mode
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R7");
        // R2 R3 sparse ticks
        for (int i = 0; i < 30; i++) step((i % 3) != 0, 1'b0, "R2");
        // R10 mode toggles every seven cycles
        for (int i = 0; i < 56; i++) step(1'b1, (i / 7) % 2 == 1, "R10");
        // R6 R3 mixed ticks and modes
        for (int i = 0; i < 24; i++) step((i % 2) == 0, (i % 5) < 2, "R6");

        // R8 run long until the low nine stages are zero, then enter short mode
        guard_hits = 0;
        for (int i = 0; i < 140000 && guard_hits == 0; i++) begin
            step(1'b1, 1'b0, "R4");
            if (m17[8:0] == 9'd0) guard_hits = 1;
        end
        chk(guard_hits == 1, "R8", $sformatf("got zero window found=%0d exp 1", guard_hits));
        step(1'b1, 1'b1, "R8");
        sample();
        chk(rand_o == m17[16:9] && m17[0] == 1'b1, "R8",
            $sformatf("got rnd=%02h lsb=%0b exp rnd=%02h lsb=1", rand_o, m17[0], m17[16:9]));
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, "R8");
        step(1'b0, 1'b1, "R7");

        // R9 four-stage period 15
        for (int i = 0; i < 15; i++) begin step(1'b1, 1'b0, "R2"); sample(); seq4a[i] = noise4_o; end
        for (int i = 0; i < 15; i++) begin step(1'b1, 1'b0, "R2"); sample(); seq4b[i] = noise4_o; end
        chk(seq4a == seq4b, "R9", $sformatf("got %h exp %h", seq4b, seq4a));
        // R9 five-stage period 31
        for (int i = 0; i < 31; i++) begin step(1'b1, 1'b0, "R3"); sample(); seq5a[i] = noise5_o; end
        for (int i = 0; i < 31; i++) begin step(1'b1, 1'b0, "R3"); sample(); seq5b[i] = noise5_o; end
        chk(seq5a == seq5b, "R9", $sformatf("got %h exp %h", seq5b, seq5a));

        // R9 short-mode period 511
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R5");
        sample();
        snap = rand_o;
        for (int i = 0; i < 511; i++) step(1'b1, 1'b1, "R5");
        sample();
        chk(rand_o == snap, "R9", $sformatf("got %02h exp %02h", rand_o, snap));

        // R9 long-mode period 131071
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R4");
        sample();
        snap = rand_o;
        for (int i = 0; i < 131071; i++) step(1'b1, 1'b0, "R4");
        sample();
        chk(rand_o == snap, "R9", $sformatf("got %02h exp %02h", rand_o, snap));
        step(1'b0, 1'b0, "R7");

        // R1 reset in the middle of a run, with a tick pending
        @(negedge clk);
        rst = 1'b1;
        tick_i = 1'b1;
        short_mode_i = 1'b1;
        sample();
        model_reset();
        chk(noise4_o && noise5_o && noise17_o && rand_o == 8'hFF, "R1",
            $sformatf("got b4=%0b b5=%0b b17=%0b rnd=%02h exp 1 1 1 ff",
                      noise4_o, noise5_o, noise17_o, rand_o));
        @(negedge clk);
        rst = 1'b0;
        tick_i = 1'b0;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, "R5");
        step(1'b0, 1'b1, "R7");
        sample();
        sample();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule